// File: doc/BRIEF.md
# Frame-Paced Microcontroller PCM Access Buffer

This block lets a microcontroller step into the per-channel PCM sample streams of a four-channel voice path, one channel at a time, with every exchange paced by the frame sync. In insertion mode the controller supplies one byte per frame, and that byte replaces the receive sample of the selected channel. In capture mode the block latches the selected channel's transmit sample once per frame, and the controller reads it back.

The controller has a one-bit register address, a write strobe, a read strobe and an 8-bit data bus. Address 0 is the data register: a write loads the insertion byte and a read returns the captured byte. Address 1 is the status register. Each mode has a request flag and an error flag. The insertion error flag records a frame that passed with no new byte, in which case the old byte goes out again. The capture error flag records a captured byte that was overwritten before the controller read it. A level interrupt stays high while an enabled request is pending.

Top module: `pcm_mcu_access`

## Requirements
- R1: After reset all four flags, `irq` and the captured byte are 0, and every `rx_out` lane equals the matching `rx_in` lane.
- R2: `chan_sel` is a plain binary channel number with bit 0 as the LSB (0 to 3). Only lane `chan_sel` of `rx_out` is substituted and only lane `chan_sel` of `tx_in` is captured. Lane k sits at bits [8k+7:8k].
- R3: A frame event with `wr_mode` high sets `flag_wreq` at that same clock edge. A frame event is the first cycle of `fsync` high after it was low.
- R4: A write to address 0 clears `flag_wreq` and stores the byte. That byte drives the selected `rx_out` lane from the next frame event on, for as long as `wr_mode` is high.
- R5: A frame event in insertion mode while `flag_wreq` is still set, with no data write in that cycle, sets `flag_miss` and inserts the previous byte again. A data write in the same cycle as the frame counts as on time.
- R6: A frame event with `rd_mode` high latches the selected `tx_in` lane into the capture register and sets `flag_rrdy`.
- R7: Address 0 reads return the captured byte, and a read strobe to address 0 clears `flag_rrdy`.
- R8: A frame event in capture mode while `flag_rrdy` is still set, with no data read in that cycle, overwrites the captured byte and sets `flag_ovr`.
- R9: Address 1 reads return {4'b0, ovr, miss, rrdy, wreq} (bit 0 is wreq). A read strobe to address 1 clears only `flag_miss` and `flag_ovr`. Both flags are sticky until then.
- R10: `irq` is high exactly while (`flag_wreq` and `wr_mode`) or (`flag_rrdy` and `rd_mode`).
- R11: With both modes low, a frame event changes no flag and no captured byte, and all `rx_out` lanes equal `rx_in`.
- R12: `fsync` held high for several cycles is one frame event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_sel | input | 2 | Selected channel number |
| wr_mode | input | 1 | Insertion mode enable |
| rd_mode | input | 1 | Capture mode enable |
| fsync | input | 1 | Frame sync, rising edge starts a frame |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = data register, 1 = status register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| rx_in | input | 32 | Receive samples, four 8-bit lanes |
| rx_out | output | 32 | Receive samples after substitution |
| tx_in | input | 32 | Transmit samples, four 8-bit lanes |
| tx_capt | output | 8 | Captured transmit byte |
| irq | output | 1 | Level interrupt |
| flag_wreq | output | 1 | Insertion byte requested |
| flag_rrdy | output | 1 | Captured byte ready |
| flag_miss | output | 1 | Frame passed without a new insertion byte (sticky) |
| flag_ovr | output | 1 | Captured byte overwritten unread (sticky) |

## Verification
The hardest cases to reach are the ones where a controller access falls in the same clock as a frame event. There, a write must still count as on time, and a late request must still raise the sticky error flag. The stimulus gets there by placing the write strobe and the rising `fsync` on the same edge. It also holds `fsync` high over several cycles to show that this yields only one event. The error flags are raised by running frames back to back with no access in between, and they are then cleared through the status read path.

// File: rtl/pcm_acc_pkg.sv
package pcm_acc_pkg;

  typedef struct packed {
    logic ovr;
    logic miss;
    logic rrdy;
    logic wreq;
  } pcm_flags_t;

  // status word layout: upper bits zero, flag nibble in the low bits
  function automatic logic [7:0] pack_status(input pcm_flags_t f);
    return {4'b0000, f};
  endfunction

  // one cycle event on the first high sample of the frame sync
  function automatic logic frame_edge(input logic now, input logic prev);
    return now & ~prev;
  endfunction

endpackage

// File: rtl/pcm_acc_wpath.sv
module pcm_acc_wpath #(
  parameter int NCH = 4,
  parameter int W   = 8,
  parameter int SW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_evt,
  input  logic           wr_mode,
  input  logic [SW-1:0]  sel,
  input  logic           data_wr,
  input  logic           stat_rd,
  input  logic [W-1:0]   wdata,
  input  logic [NCH*W-1:0] rx_in,
  output logic [NCH*W-1:0] rx_out,
  output logic           wreq,
  output logic           miss,
  output logic           miss_evt
);

  logic [W-1:0] wbuf;
  logic [W-1:0] ins_byte;
  logic         wr_frame;

  assign wr_frame = frame_evt & wr_mode;
  assign miss_evt = wr_frame & wreq & ~data_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wbuf     <= '0;
      ins_byte <= '0;
      wreq     <= 1'b0;
      miss     <= 1'b0;
    end else begin
      if (data_wr) wbuf <= wdata;
      if (wr_frame) ins_byte <= data_wr ? wdata : wbuf;
      if (wr_frame)     wreq <= 1'b1;
      else if (data_wr) wreq <= 1'b0;
      if (miss_evt)     miss <= 1'b1;
      else if (stat_rd) miss <= 1'b0;
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_lane
    assign rx_out[k*W +: W] = (wr_mode && sel == SW'(k)) ? ins_byte
                                                         : rx_in[k*W +: W];
  end

endmodule

// File: rtl/pcm_acc_rpath.sv
module pcm_acc_rpath #(
  parameter int NCH = 4,
  parameter int W   = 8,
  parameter int SW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_evt,
  input  logic           rd_mode,
  input  logic [SW-1:0]  sel,
  input  logic           data_rd,
  input  logic           stat_rd,
  input  logic [NCH*W-1:0] tx_in,
  output logic [W-1:0]   capt,
  output logic           rrdy,
  output logic           ovr,
  output logic           ovr_evt
);

  logic         rd_frame;
  logic [W-1:0] lane_sel;

  assign rd_frame = frame_evt & rd_mode;
  assign ovr_evt  = rd_frame & rrdy & ~data_rd;
  assign lane_sel = tx_in[sel*W +: W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      capt <= '0;
      rrdy <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (rd_frame)     capt <= lane_sel;
      if (rd_frame)     rrdy <= 1'b1;
      else if (data_rd) rrdy <= 1'b0;
      if (ovr_evt)      ovr  <= 1'b1;
      else if (stat_rd) ovr  <= 1'b0;
    end
  end

endmodule

// File: rtl/pcm_mcu_access.sv
module pcm_mcu_access
  import pcm_acc_pkg::*;
#(
  parameter int NCH = 4,
  parameter int W   = 8,
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SW-1:0]    chan_sel,
  input  logic             wr_mode,
  input  logic             rd_mode,
  input  logic             fsync,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic             reg_addr,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata,
  input  logic [NCH*W-1:0] rx_in,
  output logic [NCH*W-1:0] rx_out,
  input  logic [NCH*W-1:0] tx_in,
  output logic [W-1:0]     tx_capt,
  output logic             irq,
  output logic             flag_wreq,
  output logic             flag_rrdy,
  output logic             flag_miss,
  output logic             flag_ovr
);

  logic       fs_q;
  logic       frame_evt;
  logic       data_wr, data_rd, stat_rd;
  logic       miss_evt, ovr_evt;
  pcm_flags_t flags;

  always_ff @(posedge clk) begin
    if (!rst_n) fs_q <= 1'b0;
    else        fs_q <= fsync;
  end

  assign frame_evt = frame_edge(fsync, fs_q);
  assign data_wr   = reg_wr & ~reg_addr;
  assign data_rd   = reg_rd & ~reg_addr;
  assign stat_rd   = reg_rd &  reg_addr;

  pcm_acc_wpath #(.NCH(NCH), .W(W), .SW(SW)) u_wpath (
    .clk(clk), .rst_n(rst_n), .frame_evt(frame_evt), .wr_mode(wr_mode),
    .sel(chan_sel), .data_wr(data_wr), .stat_rd(stat_rd), .wdata(wdata),
    .rx_in(rx_in), .rx_out(rx_out), .wreq(flag_wreq), .miss(flag_miss),
    .miss_evt(miss_evt)
  );

  pcm_acc_rpath #(.NCH(NCH), .W(W), .SW(SW)) u_rpath (
    .clk(clk), .rst_n(rst_n), .frame_evt(frame_evt), .rd_mode(rd_mode),
    .sel(chan_sel), .data_rd(data_rd), .stat_rd(stat_rd), .tx_in(tx_in),
    .capt(tx_capt), .rrdy(flag_rrdy), .ovr(flag_ovr), .ovr_evt(ovr_evt)
  );

  assign flags = '{ovr: flag_ovr, miss: flag_miss, rrdy: flag_rrdy, wreq: flag_wreq};
  assign rdata = reg_addr ? W'(pack_status(flags)) : tx_capt;
  assign irq   = (flag_wreq & wr_mode) | (flag_rrdy & rd_mode);

endmodule

// File: rtl/pcm_acc_chk.sv
module pcm_acc_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_evt,
  input logic wr_mode,
  input logic rd_mode,
  input logic data_wr,
  input logic data_rd,
  input logic stat_rd,
  input logic reg_wr,
  input logic reg_rd,
  input logic miss_evt,
  input logic ovr_evt,
  input logic wreq,
  input logic rrdy,
  input logic miss,
  input logic ovr,
  input logic irq
);

  p_wreq_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt && wr_mode |=> wreq && irq);

  p_miss_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt && wr_mode && wreq && !data_wr |=> miss);

  p_rrdy_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt && rd_mode |=> rrdy);

  p_rrdy_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && !(frame_evt && rd_mode) |=> !rrdy);

  p_ovr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt && rd_mode && rrdy && !data_rd |=> ovr);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (miss || ovr) && !stat_rd |=> $stable({miss, ovr}) || $rose(miss) || $rose(ovr));

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mode && !rd_mode |-> !irq);

  p_idle_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt && !wr_mode && !rd_mode && !reg_wr && !reg_rd
      |=> $stable({wreq, rrdy, miss, ovr}));

  p_single_event_r12: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt |=> !frame_evt);

  p_err_events_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(miss_evt) && $onehot0(ovr_evt) && (!miss_evt || frame_evt));

endmodule

bind pcm_mcu_access pcm_acc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_evt(frame_evt), .wr_mode(wr_mode),
  .rd_mode(rd_mode), .data_wr(data_wr), .data_rd(data_rd), .stat_rd(stat_rd),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .miss_evt(miss_evt), .ovr_evt(ovr_evt),
  .wreq(flag_wreq), .rrdy(flag_rrdy), .miss(flag_miss), .ovr(flag_ovr),
  .irq(irq)
);

// File: tb/pcm_mcu_access_test.sv
module pcm_mcu_access_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  chan_sel;
  logic        wr_mode, rd_mode, fsync, reg_wr, reg_rd, reg_addr;
  logic [7:0]  wdata, rdata, tx_capt;
  logic [31:0] rx_in, rx_out, tx_in;
  logic        irq, flag_wreq, flag_rrdy, flag_miss, flag_ovr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  pcm_mcu_access uut (
    .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .wr_mode(wr_mode),
    .rd_mode(rd_mode), .fsync(fsync), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .wdata(wdata), .rdata(rdata), .rx_in(rx_in),
    .rx_out(rx_out), .tx_in(tx_in), .tx_capt(tx_capt), .irq(irq),
    .flag_wreq(flag_wreq), .flag_rrdy(flag_rrdy), .flag_miss(flag_miss),
    .flag_ovr(flag_ovr)
  );

  // op: 0 frame (arg = selected tx lane), 1 data write, 2 data read, 3 status read
  typedef struct packed {
    logic [1:0] op;
    logic [7:0] arg;
    logic [3:0] stat;  // {ovr, miss, rrdy, wreq} after the op
    logic [7:0] lane;  // rx_out lane 2 after the op
    logic [7:0] rd;    // rdata during a read op
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{2'd0, 8'hA1, 4'b0011, 8'h00, 8'h00},
    '{2'd1, 8'h55, 4'b0010, 8'h00, 8'h00},
    '{2'd2, 8'h00, 4'b0000, 8'h00, 8'hA1},
    '{2'd0, 8'hB2, 4'b0011, 8'h55, 8'h00},
    '{2'd0, 8'hC3, 4'b1111, 8'h55, 8'h00},
    '{2'd3, 8'h00, 4'b0011, 8'h55, 8'h0F},
    '{2'd2, 8'h00, 4'b0001, 8'h55, 8'hC3},
    '{2'd1, 8'h66, 4'b0000, 8'h55, 8'h00},
    '{2'd0, 8'hD4, 4'b0011, 8'h66, 8'h00},
    '{2'd3, 8'h00, 4'b0011, 8'h66, 8'h03}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] flags_now();
    return {flag_ovr, flag_miss, flag_rrdy, flag_wreq};
  endfunction

  task automatic do_frame(input int hold);
    @(negedge clk) fsync = 1'b1;
    repeat (hold) @(negedge clk);
    fsync = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk) begin reg_wr = 1'b1; reg_addr = 1'b0; wdata = d; end
    @(negedge clk) reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic a, output logic [7:0] d);
    @(negedge clk) begin reg_rd = 1'b1; reg_addr = a; end
    #1 d = rdata;
    @(negedge clk) reg_rd = 1'b0;
  endtask

  task automatic set_tx(input logic [1:0] c, input logic [7:0] v);
    for (int k = 0; k < 4; k++) tx_in[k*8 +: 8] = (k == c) ? v : ~v;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    rst_n = 1'b0; chan_sel = 2'd0; wr_mode = 1'b0; rd_mode = 1'b0; fsync = 1'b0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 1'b0; wdata = 8'h00; tx_in = '0;
    for (int k = 0; k < 4; k++) rx_in[k*8 +: 8] = 8'h10 + 8'(k);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 flags", {28'd0, flags_now()}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 rx pass", rx_out, rx_in);
    check("R1 capt", {24'd0, tx_capt}, 32'd0);

    // table walk: both modes, channel 2
    wr_mode = 1'b1; rd_mode = 1'b1; chan_sel = 2'd2;
    for (int i = 0; i < 10; i++) begin
      rv = 8'h00;
      case (VEC[i].op)
        2'd0: begin set_tx(2'd2, VEC[i].arg); do_frame(1); end
        2'd1: do_write(VEC[i].arg);
        2'd2: do_read(1'b0, rv);
        default: do_read(1'b1, rv);
      endcase
      #1;
      check($sformatf("R3/R5/R6/R8/R9 flags vec %0d", i), {28'd0, flags_now()}, {28'd0, VEC[i].stat});
      check($sformatf("R4/R5 lane vec %0d", i), {24'd0, rx_out[16 +: 8]}, {24'd0, VEC[i].lane});
      if (VEC[i].op[1]) check($sformatf("R7/R9 rdata vec %0d", i), {24'd0, rv}, {24'd0, VEC[i].rd});
    end

    // R10: irq follows enabled requests
    check("R10 irq set", {31'd0, irq}, 32'd1);
    wr_mode = 1'b0; rd_mode = 1'b0; #1;
    check("R10 irq masked", {31'd0, irq}, 32'd0);

    // R11: idle frame changes nothing
    set_tx(2'd2, 8'hE5);
    do_frame(1); #1;
    check("R11 flags", {28'd0, flags_now()}, 32'h3);
    check("R11 capt", {24'd0, tx_capt}, 32'hD4);
    check("R11 rx pass", rx_out, rx_in);

    do_read(1'b0, rv); do_write(8'h77); #1;
    check("R7 R4 cleared", {28'd0, flags_now()}, 32'd0);

    // R2: insertion on each channel
    wr_mode = 1'b1;
    for (int c = 0; c < 4; c++) begin
      chan_sel = 2'(c);
      do_write(8'h80 + 8'(c));
      do_frame(1); #1;
      for (int k = 0; k < 4; k++)
        check($sformatf("R2 ins ch%0d lane%0d", c, k), {24'd0, rx_out[k*8 +: 8]},
              {24'd0, (k == c) ? 8'h80 + 8'(c) : 8'h10 + 8'(k)});
    end
    check("R5 no miss", {31'd0, flag_miss}, 32'd0);
    do_write(8'h00);
    wr_mode = 1'b0;

    // R2: capture from each channel
    rd_mode = 1'b1;
    for (int k = 0; k < 4; k++) tx_in[k*8 +: 8] = 8'h20 + 8'(k);
    for (int c = 0; c < 4; c++) begin
      chan_sel = 2'(c);
      do_frame(1);
      do_read(1'b0, rv);
      check($sformatf("R2 capt ch%0d", c), {24'd0, rv}, {24'd0, 8'h20 + 8'(c)});
    end

    // R12: long frame sync gives one event
    do_frame(5); #1;
    check("R12 one event", {28'd0, flags_now()}, 32'h2);
    do_read(1'b0, rv);
    rd_mode = 1'b0;

    // R5: write in the same cycle as a frame is on time
    wr_mode = 1'b1; chan_sel = 2'd1;
    do_frame(1);
    @(negedge clk) begin reg_wr = 1'b1; reg_addr = 1'b0; wdata = 8'h9A; fsync = 1'b1; end
    @(negedge clk) begin reg_wr = 1'b0; fsync = 1'b0; end
    #1;
    check("R5 same-cycle write no miss", {28'd0, flags_now()}, 32'h1);
    check("R4 same-cycle byte", {24'd0, rx_out[8 +: 8]}, 32'h9A);
    // R5: late frame repeats byte and flags miss
    do_frame(1); #1;
    check("R5 repeat byte", {24'd0, rx_out[8 +: 8]}, 32'h9A);
    check("R5 miss sticky", {31'd0, flag_miss}, 32'd1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule